// File: doc/BRIEF.md
# Serial DAC Frame Sequencer

This controller sits on the host side of a quad 12-bit serial-input converter. It takes a single write request carrying a channel number and a sample code. It then builds a 16-bit word and shifts it out on a chip-select / serial-clock / serial-data triple. After the word is complete it issues an active-low load strobe that moves the word into the addressed converter register, and it reports completion. The converter combines the serial clock and the chip select in an OR gate. For that reason the sequencer places every chip-select transition inside a high phase of the serial clock. It also ends each frame with the clock parked high, so that the combined clock shows exactly sixteen rising edges per frame.

The block also offers a clear function. A clear request drives an active-low clear pulse and a select line that tells the converter whether to clear to zero scale or to midscale. The clear pulse never overlaps a frame. If a clear is requested while a frame is running, it waits and starts after the load strobe. The sampling instants are set in whole system clocks by parameters, each clamped to a minimum of one: the serial clock half period, the chip-select setup before the first falling clock, the load pulse width and the clear pulse width.

Top module: `dac_frame_sequencer`

## Requirements
- R1: The word is sent MSB first. Bits 15:14 carry the channel number, bits 13:12 are filler sent as 0, and bits 11:0 carry the code, MSB first.
- R2: Each frame shows exactly 16 rising edges on the combined clock (serial clock OR chip select). Serial data changes only on a falling serial-clock edge, so each bit is stable at its rising edge.
- R3: The serial clock idles high whenever chip select is high. Inside a frame, each low phase and each high phase lasts HALF_CYC system clocks.
- R4: Chip select falls only while the serial clock is high. It stays low for SETUP_CYC system clocks before the first falling serial-clock edge.
- R5: After the 16th rising edge the serial clock stays high until chip select has returned high.
- R6: The load strobe goes low for LOAD_CYC system clocks, only after chip select is high again. No combined-clock edge occurs while it is low, and it is high again before the next frame begins.
- R7: busy rises in the cycle after a request is accepted and falls in the cycle in which the load strobe returns high. done is high for exactly that one cycle.
- R8: A write request presented while busy is high is ignored.
- R9: A clear request drives the clear output low for CLEAR_CYC system clocks. During the pulse the clear-select output holds the select captured with the request (1 = midscale 0x800, 0 = zero scale).
- R10: A clear pulse never overlaps a frame. A clear requested during a frame starts after that frame's load strobe. When a write and a clear arrive in the same idle cycle, the write goes first.
- R11: A write request presented while the clear output is low is ignored.
- R12: After reset, chip select, serial clock, load strobe and clear outputs are all high, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request, sampled on each rising clock |
| wr_chan | input | CHAN_W | Channel number of the write |
| wr_code | input | CODE_W | Code to write |
| clr_req | input | 1 | Clear request |
| clr_mid_sel | input | 1 | Clear target: 1 midscale, 0 zero scale |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_sel_n | output | 1 | Converter chip select, active low |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdata | output | 1 | Serial data |
| dac_load_n | output | 1 | Register load strobe, active low |
| dac_clear_n | output | 1 | Clear pulse, active low |
| dac_clear_mid | output | 1 | Clear target select |

## Verification
A write and a clear can arrive in the same idle cycle, and a clear can also arrive in the middle of a frame. Both cases exercise the arbitration between the shift sequence and the clear pulse. The bench provokes each case with directed stimulus. A model of the converter, fed from the output pins, rebuilds the register contents. The bench checks that the written code is latched first and then overwritten by the clear value. It also checks that no clear-low cycle ever coincides with chip select low or with busy.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_CLK_LO  = 3'd2,
    ST_CLK_HI  = 3'd3,
    ST_RELEASE = 3'd4,
    ST_STROBE  = 3'd5
  } seq_state_t;

  function automatic int unsigned clamp1(input int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_seq_shifter.sv
module dac_seq_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               shift,
  output logic               sdata,
  output logic               last
);

  localparam int unsigned CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] data_q, data_d;
  logic [CW-1:0]      left_q, left_d;

  always_comb begin
    data_d = data_q;
    left_d = left_q;
    if (load) begin
      data_d = frame_in;
      left_d = CW'(FRAME_W);
    end else if (shift) begin
      data_d = {data_q[FRAME_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      left_q <= '0;
    end else begin
      data_q <= data_d;
      left_q <= left_d;
    end
  end

  assign sdata = data_q[FRAME_W-1];
  assign last  = (left_q == CW'(1));

endmodule

// File: rtl/dac_seq_clear.sv
module dac_seq_clear #(
  parameter int unsigned PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mid_in,
  output logic clear_n,
  output logic clear_mid,
  output logic active
);

  localparam int unsigned CW = $clog2(PULSE + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mid_q, mid_d;
  logic          clear_n_q, clear_n_d;

  always_comb begin
    cnt_d = cnt_q;
    mid_d = mid_q;
    if (start) begin
      cnt_d = CW'(PULSE);
      mid_d = mid_in;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    clear_n_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      mid_q     <= 1'b0;
      clear_n_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      mid_q     <= mid_d;
      clear_n_q <= clear_n_d;
    end
  end

  assign clear_n   = clear_n_q;
  assign clear_mid = mid_q;
  assign active    = (cnt_q != '0);

endmodule

// File: rtl/dac_frame_sequencer.sv
module dac_frame_sequencer
  import dac_seq_pkg::*;
#(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned FILL_W    = 2,
  parameter int unsigned HALF_CYC  = 2,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned LOAD_CYC  = 2,
  parameter int unsigned CLEAR_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              clr_req,
  input  logic              clr_mid_sel,
  output logic              busy,
  output logic              done,
  output logic              dac_sel_n,
  output logic              dac_sclk,
  output logic              dac_sdata,
  output logic              dac_load_n,
  output logic              dac_clear_n,
  output logic              dac_clear_mid
);

  localparam int unsigned FRAME_W = CHAN_W + FILL_W + CODE_W;
  localparam int unsigned HALF_E  = clamp1(HALF_CYC);
  localparam int unsigned SETUP_E = clamp1(SETUP_CYC);
  localparam int unsigned LOAD_E  = clamp1(LOAD_CYC);
  localparam int unsigned CLR_E   = clamp1(CLEAR_CYC);
  localparam int unsigned MAXD    = max3(HALF_E, SETUP_E, LOAD_E);
  localparam int unsigned TW      = $clog2(MAXD + 1);

  seq_state_t state_q, state_d;

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;
  logic          sh_load, sh_shift, sh_last;
  logic          done_q, done_d;
  logic          sel_n_q, sclk_q, load_n_q;
  logic          accept_wr;
  logic          clr_active, clr_start, clr_pick;
  logic          pend_q, pend_d, pend_mid_q, pend_mid_d;
  logic [FRAME_W-1:0] frame_word;

  assign frame_word = {wr_chan, {FILL_W{1'b0}}, wr_code};
  assign accept_wr  = wr_valid && (state_q == ST_IDLE) && !clr_active;

  // Sequencing of the shift frame
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_wr) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETUP_E - 1);
          sh_load  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          state_d  = ST_CLK_LO;
          tmr_load = 1'b1;
          tmr_val  = TW'(HALF_E - 1);
        end
      end
      ST_CLK_LO: begin
        if (tmr_exp) begin
          state_d  = ST_CLK_HI;
          tmr_load = 1'b1;
          tmr_val  = TW'(HALF_E - 1);
        end
      end
      ST_CLK_HI: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (sh_last) begin
            state_d = ST_RELEASE;
            tmr_val = '0;
          end else begin
            state_d  = ST_CLK_LO;
            tmr_val  = TW'(HALF_E - 1);
            sh_shift = 1'b1;
          end
        end
      end
      ST_RELEASE: begin
        if (tmr_exp) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = TW'(LOAD_E - 1);
        end
      end
      ST_STROBE: begin
        if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Clear arbitration: a write accepted in the same idle cycle goes first
  always_comb begin
    clr_start  = (pend_q || clr_req) && (state_q == ST_IDLE) && !accept_wr && !clr_active;
    clr_pick   = clr_req ? clr_mid_sel : pend_mid_q;
    pend_mid_d = clr_req ? clr_mid_sel : pend_mid_q;
    pend_d     = pend_q;
    if (clr_start) begin
      pend_d = 1'b0;
    end else if (clr_req) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done_q     <= 1'b0;
      sel_n_q    <= 1'b1;
      sclk_q     <= 1'b1;
      load_n_q   <= 1'b1;
      pend_q     <= 1'b0;
      pend_mid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      done_q     <= done_d;
      sel_n_q    <= !((state_d == ST_SETUP) || (state_d == ST_CLK_LO) ||
                      (state_d == ST_CLK_HI));
      sclk_q     <= (state_d != ST_CLK_LO);
      load_n_q   <= (state_d != ST_STROBE);
      pend_q     <= pend_d;
      pend_mid_q <= pend_mid_d;
    end
  end

  dac_seq_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  dac_seq_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .frame_in (frame_word),
    .shift    (sh_shift),
    .sdata    (dac_sdata),
    .last     (sh_last)
  );

  dac_seq_clear #(.PULSE(CLR_E)) u_clear (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (clr_start),
    .mid_in    (clr_pick),
    .clear_n   (dac_clear_n),
    .clear_mid (dac_clear_mid),
    .active    (clr_active)
  );

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign dac_sel_n  = sel_n_q;
  assign dac_sclk   = sclk_q;
  assign dac_load_n = load_n_q;

endmodule

// File: rtl/dac_frame_sequencer_chk.sv
module dac_frame_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sel_n,
  input logic sclk,
  input logic load_n,
  input logic clear_n
);

  AST_CLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> sclk); // R3

  AST_SEL_FALL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (sclk && $past(sclk))); // R4

  AST_SEL_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (sclk && $past(sclk))); // R5

  AST_NO_CLOCK_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> (sel_n && sclk)); // R6

  AST_LOAD_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> $past(sel_n)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_BUSY_ENDS_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_n) |-> (done && !busy && $past(busy))); // R7

  AST_CLEAR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (sel_n && load_n && !busy)); // R10

endmodule

bind dac_frame_sequencer dac_frame_sequencer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .sel_n   (dac_sel_n),
  .sclk    (dac_sclk),
  .load_n  (dac_load_n),
  .clear_n (dac_clear_n)
);

// File: tb/dac_frame_sequencer_bench.sv
module dac_frame_sequencer_bench;

  localparam int HALF  = 2;
  localparam int SETUP = 2;
  localparam int LOADW = 3;
  localparam int CLRW  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        wr_valid;
  logic [1:0]  wr_chan;
  logic [11:0] wr_code;
  logic        clr_req, clr_mid_sel;
  logic        busy, done, dac_sel_n, dac_sclk, dac_sdata, dac_load_n;
  logic        dac_clear_n, dac_clear_mid;

  dac_frame_sequencer #(
    .HALF_CYC(HALF), .SETUP_CYC(SETUP), .LOAD_CYC(LOADW), .CLEAR_CYC(CLRW)
  ) u_dac_frame_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_code(wr_code), .clr_req(clr_req), .clr_mid_sel(clr_mid_sel),
    .busy(busy), .done(done), .dac_sel_n(dac_sel_n), .dac_sclk(dac_sclk),
    .dac_sdata(dac_sdata), .dac_load_n(dac_load_n), .dac_clear_n(dac_clear_n),
    .dac_clear_mid(dac_clear_mid)
  );

  int checks = 0;
  int errors = 0;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Converter model driven from the pins
  logic [15:0] sh_m, last_frame;
  logic [11:0] regs_m [4];
  int edge_cnt, last_edges, loads, clk_in_load, overlap;
  int lo_run, lo_min, lo_max, setup_run, setup_meas, clr_run, clr_len;
  int done_long;
  bit first_fall;
  logic prev_or, prev_load, prev_sclk, prev_done, prev_clr, or_c;

  always @(negedge clk) begin
    if (!rst_n) begin
      sh_m = '0; last_frame = '0; edge_cnt = 0; last_edges = 0; loads = 0;
      clk_in_load = 0; overlap = 0; lo_run = 0; lo_min = 1000; lo_max = 0;
      setup_run = 0; setup_meas = 0; clr_run = 0; clr_len = 0; done_long = 0;
      first_fall = 0;
      prev_or = 1; prev_load = 1; prev_sclk = 1; prev_done = 0; prev_clr = 1;
      for (int k = 0; k < 4; k++) regs_m[k] = '0;
    end else begin
      or_c = dac_sclk | dac_sel_n;
      if (or_c && !prev_or) begin
        sh_m = {sh_m[14:0], dac_sdata};
        edge_cnt++;
        if (!dac_load_n) clk_in_load++;
      end
      if (!dac_load_n && prev_load) begin
        last_frame = sh_m;
        last_edges = edge_cnt;
        edge_cnt = 0;
        loads++;
        regs_m[sh_m[15:14]] = sh_m[11:0];
      end
      if (!dac_sclk) lo_run++;
      else if (!prev_sclk) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
        lo_run = 0;
      end
      if (dac_sel_n) begin
        first_fall = 0;
        setup_run = 0;
      end else if (!first_fall) begin
        if (dac_sclk) setup_run++;
        else begin
          setup_meas = setup_run;
          first_fall = 1;
        end
      end
      if (!dac_clear_n) begin
        clr_run++;
        for (int k = 0; k < 4; k++) regs_m[k] = dac_clear_mid ? 12'h800 : 12'h000;
        if (!dac_sel_n || busy || !dac_load_n) overlap++;
      end else if (!prev_clr) begin
        clr_len = clr_run;
        clr_run = 0;
      end
      if (done && prev_done) done_long++;
      prev_or = or_c; prev_load = dac_load_n; prev_sclk = dac_sclk;
      prev_done = done; prev_clr = dac_clear_n;
    end
  end

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check_eq({tag, " done seen"}, int'(done), 1);
  endtask

  task automatic do_write(input logic [1:0] ch, input logic [11:0] code);
    @(negedge clk);
    wr_valid = 1; wr_chan = ch; wr_code = code;
    @(negedge clk);
    wr_valid = 0;
    check_eq("R7 busy after accept", int'(busy), 1);
    wait_done("R7");
    check_eq("R7 busy low with done", int'(busy), 0);
    check_eq("R6 load high at done", int'(dac_load_n), 1);
    check_eq("R1 frame word", int'(last_frame), int'({ch, 2'b00, code}));
    check_eq("R2 edges per frame", last_edges, 16);
    check_eq("R6 register loaded", int'(regs_m[ch]), int'(code));
    @(negedge clk);
    check_eq("R7 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset;
    check_eq("R12 sel_n", int'(dac_sel_n), 1);
    check_eq("R12 sclk", int'(dac_sclk), 1);
    check_eq("R12 load_n", int'(dac_load_n), 1);
    check_eq("R12 clear_n", int'(dac_clear_n), 1);
    check_eq("R12 busy", int'(busy), 0);
    check_eq("R12 done", int'(done), 0);
  endtask

  task automatic t_writes;
    do_write(2'd0, 12'hA5C);
    do_write(2'd1, 12'h3F0);
    do_write(2'd2, 12'hFFF);
    do_write(2'd3, 12'h001);
    check_eq("R1 ch0 kept", int'(regs_m[0]), 'hA5C);
  endtask

  task automatic t_timing;
    check_eq("R3 min low phase", lo_min, HALF);
    check_eq("R3 max low phase", lo_max, HALF);
    check_eq("R4 setup before first fall", setup_meas, SETUP);
    check_eq("R6 no clock while load low", clk_in_load, 0);
    check_eq("R7 done never two cycles", done_long, 0);
    check_eq("R5 no extra edge after frame", edge_cnt, 0);
  endtask

  task automatic t_busy_ignore;
    int l0;
    l0 = loads;
    @(negedge clk);
    wr_valid = 1; wr_chan = 2'd1; wr_code = 12'h123;
    @(negedge clk);
    wr_valid = 0;
    repeat (9) @(negedge clk);
    wr_valid = 1; wr_chan = 2'd3; wr_code = 12'h456;
    @(negedge clk);
    wr_valid = 0;
    wait_done("R8");
    repeat (20) @(negedge clk);
    check_eq("R8 one load only", loads - l0, 1);
    check_eq("R8 ch1 written", int'(regs_m[1]), 'h123);
    check_eq("R8 ch3 untouched", int'(regs_m[3]), 'h001);
    check_eq("R8 busy idle", int'(busy), 0);
  endtask

  task automatic t_clear(input logic mid);
    @(negedge clk);
    clr_req = 1; clr_mid_sel = mid;
    @(negedge clk);
    clr_req = 0;
    check_eq("R9 clear low", int'(dac_clear_n), 0);
    check_eq("R9 clear select", int'(dac_clear_mid), int'(mid));
    repeat (CLRW + 3) @(negedge clk);
    check_eq("R9 pulse width", clr_len, CLRW);
    for (int k = 0; k < 4; k++)
      check_eq("R9 register value", int'(regs_m[k]), mid ? 'h800 : 'h000);
  endtask

  task automatic t_clear_in_frame;
    @(negedge clk);
    wr_valid = 1; wr_chan = 2'd2; wr_code = 12'h777;
    @(negedge clk);
    wr_valid = 0;
    repeat (10) @(negedge clk);
    clr_req = 1; clr_mid_sel = 0;
    @(negedge clk);
    clr_req = 0;
    check_eq("R10 clear deferred", int'(dac_clear_n), 1);
    wait_done("R10");
    check_eq("R10 write landed first", int'(regs_m[2]), 'h777);
    repeat (CLRW + 3) @(negedge clk);
    check_eq("R10 cleared after frame", int'(regs_m[2]), 'h000);
    check_eq("R10 no overlap", overlap, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_valid = 1; wr_chan = 2'd0; wr_code = 12'h5A5;
    clr_req = 1; clr_mid_sel = 1;
    @(negedge clk);
    wr_valid = 0; clr_req = 0;
    check_eq("R10 write wins", int'(busy), 1);
    wait_done("R10 same cycle");
    check_eq("R10 same-cycle write landed", int'(regs_m[0]), 'h5A5);
    repeat (CLRW + 3) @(negedge clk);
    check_eq("R10 clear applied after", int'(regs_m[0]), 'h800);
    check_eq("R10 no overlap same cycle", overlap, 0);
  endtask

  task automatic t_write_in_clear;
    int l0;
    l0 = loads;
    @(negedge clk);
    clr_req = 1; clr_mid_sel = 0;
    @(negedge clk);
    clr_req = 0;
    wr_valid = 1; wr_chan = 2'd1; wr_code = 12'hABC;
    @(negedge clk);
    wr_valid = 0;
    check_eq("R11 busy stays low", int'(busy), 0);
    repeat (CLRW + 80) @(negedge clk);
    check_eq("R11 no frame", loads - l0, 0);
    check_eq("R11 ch1 cleared", int'(regs_m[1]), 'h000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; wr_valid = 0; wr_chan = '0; wr_code = '0;
    clr_req = 0; clr_mid_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_writes;
    t_timing;
    t_busy_ignore;
    t_clear(1'b1);
    t_clear(1'b0);
    t_clear_in_frame;
    t_same_cycle;
    t_write_in_clear;
    t_timing;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule